// File: doc/BRIEF.md
# Grouped Channel Conversion Start Controller

This block decides, cycle by cycle, which of a small set of sigma-delta converter channels are running and when each channel's decimation filter must be restarted. Every channel has a chain bit, a start bit and a one-shot/continuous mode bit. A set chain bit joins a channel to the channel above it. The first channel at or above it whose chain bit is clear is the group's leader, and the leader's start bit controls the whole group. The chain bit of the highest channel is forced to zero, so every chain ends at a leader.

Software start and stop requests arrive as one-cycle pulses per channel. Interrupt-flag pulses from the filters end one-shot conversions. The block also watches each channel's oversampling setting and the shared clock-divider setting. When either changes while channels are running, it sends one-cycle filter-reset pulses to the affected channels. It drives a run enable and a filter reset per channel. The filters and the register bus lie outside the block.

Top module: `sdgs_start_ctl`

## Requirements
- R1: The effective chain bit of the highest channel (`grp_o[N_CH-1]`) is always 0, whatever `grp_cfg_i` holds. The other effective chain bits follow `grp_cfg_i`.
- R2: A start pulse on a leader (a channel whose effective chain bit is 0) sets `run_o` on the cycle after the pulse for every channel whose leader it is. The leader of channel i is the lowest j ≥ i with effective chain bit j equal to 0.
- R3: A start pulse on a non-leader channel has no effect on any `run_o` bit.
- R4: A stop pulse on a leader clears `run_o` of every member of its group on the next cycle.
- R5: A stop pulse on a non-leader clears only that channel's `run_o`. Other channels are not affected.
- R6: When a running leader whose mode bit is 1 (one-shot) receives an interrupt-flag pulse, its whole group stops on the next cycle. With the mode bit at 0 (continuous), the group keeps running.
- R7: An interrupt-flag pulse on a non-leader channel has no effect on any `run_o` bit.
- R8: A stop pulse and a start pulse in the same cycle leave the channel stopped.
- R9: A change in any channel's oversampling field (`osr_cfg_i[k*OSR_W +: OSR_W]`) makes `flt_rst_o` high for exactly one cycle, in the cycle after the change, on every running member of that channel's group. `run_o` is unchanged.
- R10: A change in `div_cfg_i` makes `flt_rst_o` high for exactly one cycle, in the cycle after the change, on every running channel.
- R11: `flt_rst_o` is never high on a stopped channel. After reset, every `run_o` and `flt_rst_o` bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grp_cfg_i | input | N_CH | Chain bits as written by software |
| sng_cfg_i | input | N_CH | Mode bits: 1 one-shot, 0 continuous |
| osr_cfg_i | input | N_CH*OSR_W | Oversampling field per channel |
| div_cfg_i | input | DIV_W | Shared clock-divider setting |
| start_set_i | input | N_CH | One-cycle start request per channel |
| start_clr_i | input | N_CH | One-cycle stop request per channel |
| ifg_i | input | N_CH | One-cycle conversion-done flag per channel |
| grp_o | output | N_CH | Effective chain bits (top bit forced to 0) |
| run_o | output | N_CH | Run enable per channel |
| flt_rst_o | output | N_CH | One-cycle filter reset per channel |

## Verification
The hardest case to reach is an event on a channel whose group structure makes it behave differently: a non-leader receiving a start or done pulse, or an oversampling change on a low member of a long chain that must reach channels above it. To reach it, the bench sweeps every chain-bit pattern of a four-channel build, including patterns with the top bit set. Under each pattern it drives every event on every channel. The expected run and reset masks come from a leader search computed in the bench.

// File: rtl/sdgs_pkg.sv
package sdgs_pkg;

    localparam int SDGS_MAX_CH = 7;

    typedef logic [SDGS_MAX_CH-1:0] sdgs_vec_t;

    // Mask keeping every chain bit below the highest channel of an n-channel build.
    function automatic sdgs_vec_t sdgs_chain_mask(int n);
        sdgs_vec_t m;
        m = '0;
        for (int b = 0; b < SDGS_MAX_CH; b++) begin
            if (b < n - 1) m[b] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/sdgs_group_map.sv
module sdgs_group_map #(
    parameter int N_CH = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_CH-1:0]      geff_i,
    output logic [N_CH*N_CH-1:0] member_o
);

    // member_o[j*N_CH+i] is set when channel j leads channel i.
    always_comb begin
        member_o = '0;
        for (int i = 0; i < N_CH; i++) begin
            logic found;
            found = 1'b0;
            for (int j = 0; j < N_CH; j++) begin
                if (j >= i && !found && !geff_i[j]) begin
                    member_o[j*N_CH+i] = 1'b1;
                    found = 1'b1;
                end
            end
        end
    end

    for (genvar gi = 0; gi < N_CH; gi++) begin : g_col
        logic [N_CH-1:0] col;
        for (genvar gj = 0; gj < N_CH; gj++) begin : g_bit
            assign col[gj] = member_o[gj*N_CH+gi];
        end
        AST_ONE_LEADER: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(col) == 1); // R2
    end

endmodule

// File: rtl/sdgs_cfg_watch.sv
module sdgs_cfg_watch #(
    parameter int N_CH  = 4,
    parameter int OSR_W = 2,
    parameter int DIV_W = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_CH*OSR_W-1:0] osr_cfg_i,
    input  logic [DIV_W-1:0]      div_cfg_i,
    output logic [N_CH-1:0]       osr_chg_o,
    output logic                  div_chg_o
);

    typedef struct packed {
        logic [N_CH*OSR_W-1:0] osr;
        logic [DIV_W-1:0]      div;
    } watch_t;

    watch_t st_d, st_q;

    always_comb begin
        st_d.osr = osr_cfg_i;
        st_d.div = div_cfg_i;
        for (int k = 0; k < N_CH; k++) begin
            osr_chg_o[k] = osr_cfg_i[k*OSR_W +: OSR_W] != st_q.osr[k*OSR_W +: OSR_W];
        end
        div_chg_o = div_cfg_i != st_q.div;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_DIV_SETTLES: assert property (@(posedge clk) disable iff (!rst_n)
        (div_chg_o && $stable(div_cfg_i)) |=> !div_chg_o); // R10

endmodule

// File: rtl/sdgs_start_ctl.sv
module sdgs_start_ctl #(
    parameter int N_CH  = 4,
    parameter int OSR_W = 2,
    parameter int DIV_W = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_CH-1:0]       grp_cfg_i,
    input  logic [N_CH-1:0]       sng_cfg_i,
    input  logic [N_CH*OSR_W-1:0] osr_cfg_i,
    input  logic [DIV_W-1:0]      div_cfg_i,
    input  logic [N_CH-1:0]       start_set_i,
    input  logic [N_CH-1:0]       start_clr_i,
    input  logic [N_CH-1:0]       ifg_i,
    output logic [N_CH-1:0]       grp_o,
    output logic [N_CH-1:0]       run_o,
    output logic [N_CH-1:0]       flt_rst_o
);
    import sdgs_pkg::*;

    localparam int N_MEM = N_CH * N_CH;

    typedef struct packed {
        logic [N_CH-1:0] sc;
        logic [N_CH-1:0] rst;
    } ctl_t;

    ctl_t            ctl_d, ctl_q;
    logic [N_CH-1:0] geff;
    logic [N_MEM-1:0] member;
    logic [N_CH-1:0] osr_chg;
    logic            div_chg;
    logic [N_CH-1:0] grp_start, grp_stop, grp_osr;
    sdgs_vec_t       cmask;

    always_comb begin
        cmask = sdgs_chain_mask(N_CH);
        geff  = grp_cfg_i & cmask[N_CH-1:0];
    end

    sdgs_group_map #(.N_CH(N_CH)) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .geff_i   (geff),
        .member_o (member)
    );

    sdgs_cfg_watch #(.N_CH(N_CH), .OSR_W(OSR_W), .DIV_W(DIV_W)) u_watch (
        .clk       (clk),
        .rst_n     (rst_n),
        .osr_cfg_i (osr_cfg_i),
        .div_cfg_i (div_cfg_i),
        .osr_chg_o (osr_chg),
        .div_chg_o (div_chg)
    );

    always_comb begin
        // Group-level events, one per potential leader.
        for (int j = 0; j < N_CH; j++) begin
            grp_start[j] = !geff[j] && start_set_i[j];
            grp_stop[j]  = !geff[j] &&
                           (start_clr_i[j] || (ifg_i[j] && sng_cfg_i[j] && ctl_q.sc[j]));
            grp_osr[j]   = 1'b0;
            for (int k = 0; k < N_CH; k++) begin
                if (member[j*N_CH+k] && osr_chg[k]) grp_osr[j] = 1'b1;
            end
        end
        // Per-channel next state.
        for (int i = 0; i < N_CH; i++) begin
            logic st, sp, oc;
            st = 1'b0;
            sp = 1'b0;
            oc = 1'b0;
            for (int j = 0; j < N_CH; j++) begin
                if (member[j*N_CH+i]) begin
                    st = st | grp_start[j];
                    sp = sp | grp_stop[j];
                    oc = oc | grp_osr[j];
                end
            end
            ctl_d.sc[i]  = (ctl_q.sc[i] || st) && !(start_clr_i[i] || sp);
            ctl_d.rst[i] = ctl_q.sc[i] && ctl_d.sc[i] && (div_chg || oc);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign grp_o     = geff;
    assign run_o     = ctl_q.sc;
    assign flt_rst_o = ctl_q.rst;

    for (genvar gi = 0; gi < N_CH; gi++) begin : g_chk
        AST_CLR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
            start_clr_i[gi] |=> !run_o[gi]); // R8
        AST_RST_ONLY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
            flt_rst_o[gi] |-> run_o[gi]); // R11
        AST_SINGLE_END: assert property (@(posedge clk) disable iff (!rst_n)
            (!grp_o[gi] && sng_cfg_i[gi] && ifg_i[gi] && run_o[gi]) |=> !run_o[gi]); // R6
        AST_LEADER_START: assert property (@(posedge clk) disable iff (!rst_n)
            (!grp_o[gi] && start_set_i[gi] && !start_clr_i[gi] && !ifg_i[gi])
            |=> run_o[gi]); // R2
    end

endmodule

// File: tb/sdgs_start_ctl_tb.sv
module sdgs_start_ctl_tb;
    localparam int N  = 4;
    localparam int OW = 2;
    localparam int DW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  grp_cfg = '0, sng_cfg = '0, sset = '0, sclr = '0, ifg = '0;
    logic [N*OW-1:0] osr_cfg = '0;
    logic [DW-1:0] div_cfg = '0;
    logic [N-1:0]  grp_o, run_o, flt_rst_o;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    sdgs_start_ctl #(.N_CH(N), .OSR_W(OW), .DIV_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .grp_cfg_i(grp_cfg), .sng_cfg_i(sng_cfg),
        .osr_cfg_i(osr_cfg), .div_cfg_i(div_cfg), .start_set_i(sset),
        .start_clr_i(sclr), .ifg_i(ifg), .grp_o(grp_o), .run_o(run_o),
        .flt_rst_o(flt_rst_o)
    );

    function automatic int lead(logic [N-1:0] g, int i);
        int j;
        logic [N-1:0] e;
        e = g;
        e[N-1] = 1'b0;
        j = i;
        while (e[j]) j++;
        return j;
    endfunction

    function automatic logic [N-1:0] grp_of(logic [N-1:0] g, int l);
        logic [N-1:0] m;
        m = '0;
        for (int i = 0; i < N; i++) if (lead(g, i) == l) m[i] = 1'b1;
        return m;
    endfunction

    task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b (grp %b)", tag, act, exp, grp_cfg);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
        sset = '0; sclr = '0; ifg = '0;
    endtask

    task automatic all_on();
        sclr = '0; sset = '1; tick();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        chk("R11 reset run", run_o, '0);
        chk("R11 reset flt", flt_rst_o, '0);
        rst_n = 1'b1;
        tick();
        for (int gv = 0; gv < 16; gv++) begin
            logic [N-1:0] g, r;
            g = gv[N-1:0];
            grp_cfg = g;
            sng_cfg = '0;
            sclr = '1; tick();
            chk("R1 top chain bit", grp_o, {1'b0, g[N-2:0]});
            // start on each channel alone
            for (int k = 0; k < N; k++) begin
                sset[k] = 1'b1; tick();
                if (lead(g, k) == k) chk("R2 leader start", run_o, grp_of(g, k));
                else                 chk("R3 non-leader start", run_o, '0);
                sclr = '1; tick();
            end
            // start and stop together
            for (int k = 0; k < N; k++) begin
                sset[k] = 1'b1; sclr[k] = 1'b1; tick();
                chk("R8 stop wins", run_o & (lead(g, k) == k ? grp_of(g, k) : '0), '0);
                sclr = '1; tick();
            end
            // stop each channel
            for (int k = 0; k < N; k++) begin
                all_on();
                r = run_o;
                sclr[k] = 1'b1; tick();
                if (lead(g, k) == k) chk("R4 leader stop", run_o, r & ~grp_of(g, k));
                else begin
                    r[k] = 1'b0;
                    chk("R5 member stop", run_o, r);
                end
            end
            // done flags
            for (int k = 0; k < N; k++) begin
                sng_cfg = '1; all_on();
                ifg[k] = 1'b1; tick();
                if (lead(g, k) == k) chk("R6 one-shot end", run_o, ~grp_of(g, k));
                else                 chk("R7 member flag ignored", run_o, '1);
                sng_cfg = '0; all_on();
                ifg[k] = 1'b1; tick();
                chk("R6 continuous keeps running", run_o, '1);
            end
            // oversampling change
            for (int k = 0; k < N; k++) begin
                all_on();
                osr_cfg[k*OW] = ~osr_cfg[k*OW]; tick();
                chk("R9 osr pulse", flt_rst_o, grp_of(g, lead(g, k)));
                chk("R9 run kept", run_o, '1);
                tick();
                chk("R9 pulse ends", flt_rst_o, '0);
                sclr = '1; tick();
                osr_cfg[k*OW+1] = ~osr_cfg[k*OW+1]; tick();
                chk("R11 no pulse when stopped", flt_rst_o, '0);
            end
            // divider change
            all_on();
            sclr[0] = 1'b1; tick();
            div_cfg = div_cfg + 1'b1; tick();
            chk("R10 div pulse", flt_rst_o, 4'b1110);
            tick();
            chk("R10 pulse ends", flt_rst_o, '0);
        end
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule